// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block sits on a simple synchronous register bus and connects a processor to one character input device and one character output device. Software finds five byte-wide registers: the received character, the receive status, the character to send, the send status and an interrupt control register. Each status register carries a ready flag. The device side sets the flag and the processor's access to the matching data register clears it. Polling software spins on a status register. Interrupt-driven software sets the keyboard interrupt enable and waits for `irq`.

Both device ports are valid/ready. On the input side a character moves on every cycle with `kbd_valid` and `kbd_ready` both high. `kbd_ready` is low only during reset and high after it. The interface never applies back-pressure, so a character that arrives before software has read the previous one replaces it and is flagged as an overrun. On the output side `disp_valid` stays high and `disp_data` stays stable from the processor's write until the cycle in which `disp_ready` is seen high. The display may hold `disp_ready` low for any number of cycles.

A bus access is one cycle with `bus_sel` high. `bus_wr` selects a write. Read data appears on `bus_rdata` after the next rising edge. Side effects of the access take effect at that same edge.

Top module: `chario_mmio`

## Requirements
- R1: After reset the receive flag, the overrun bit and the interrupt enable are 0, the send flag is 1, `irq` and `disp_valid` are low, and `kbd_ready` is high.
- R2: A character accepted on the input port is stored and can be read at offset 0x0. Its arrival sets the receive flag, which is bit 3 of the receive status at offset 0x1.
- R3: A read of offset 0x0 returns the stored character and clears the receive flag. If a new character is accepted in the same cycle, the read returns the old character, the flag stays 1 and no overrun is recorded.
- R4: A character accepted while the receive flag is 1, with no read of offset 0x0 in that cycle, overwrites the stored character and sets the overrun bit, which is bit 4 of offset 0x1. A read of offset 0x1 returns the overrun bit and then clears it.
- R5: A write to offset 0x2 while the send flag is 1 drives the byte on `disp_data`, raises `disp_valid` and clears the send flag, which is bit 3 of offset 0x3. While `disp_ready` is low, `disp_valid` and `disp_data` hold.
- R6: A write to offset 0x2 while the send flag is 0 is ignored, and `disp_data` keeps the pending byte.
- R7: A cycle with `disp_valid` and `disp_ready` both high ends the transfer. After it `disp_valid` is low and the send flag reads 1.
- R8: Bit 2 of the control register at offset 0x4 is the keyboard interrupt enable. It reads back as written, and the other control bits read 0.
- R9: `irq` is high exactly while the receive flag and the keyboard interrupt enable are both 1, so it drops at the edge of the data read that clears the flag.
- R10: A read of an offset above 0x4 returns zero. Read data for any offset is on `bus_rdata` after the rising edge that ends the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| kbd_valid | input | 1 | Input device offers a character |
| kbd_ready | output | 1 | Interface accepts characters |
| kbd_data | input | 8 | Input character |
| disp_valid | output | 1 | Character pending for the display |
| disp_ready | input | 1 | Display takes the character |
| disp_data | output | 8 | Output character |
| irq | output | 1 | Keyboard interrupt request |

## Verification
Every result in this block is due one rising edge after the stimulus that causes it. The flags, the overrun bit, `irq`, `disp_valid` and `bus_rdata` all change at the edge that samples the access or the handshake. The bench therefore drives on the falling edge and samples 2 ns after the following rising edge, before any new input is applied. It checks status contents with separate reads after each event, and it checks the same-cycle cases with the input and the access driven in one cycle.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int NUM_REGS   = 5;
  localparam int OFS_RXDATA = 0;
  localparam int OFS_RXSTAT = 1;
  localparam int OFS_TXDATA = 2;
  localparam int OFS_TXSTAT = 3;
  localparam int OFS_CTRL   = 4;
  localparam int RDY_BIT    = 3;
  localparam int OVR_BIT    = 4;
  localparam int KIE_BIT    = 2;
endpackage

// File: rtl/chario_rx_chan.sv
module chario_rx_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] data_q,
  output logic              rdy_q,
  output logic              ovr_q
);
  logic accept;
  logic rdy_nxt;
  logic ovr_nxt;

  assign accept  = dev_valid & dev_ready;
  assign rdy_nxt = accept | (rdy_q & ~data_rd);
  assign ovr_nxt = (ovr_q & ~stat_rd) | (accept & rdy_q & ~data_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_ready <= 1'b0;
      data_q    <= '0;
      rdy_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      dev_ready <= 1'b1;
      rdy_q     <= rdy_nxt;
      ovr_q     <= ovr_nxt;
      if (accept) data_q <= dev_data;
    end
  end
endmodule

// File: rtl/chario_tx_chan.sv
module chario_tx_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic [DATA_W-1:0] dev_data,
  output logic              rdy
);
  logic busy_q;

  assign dev_valid = busy_q;
  assign rdy       = ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dev_data <= '0;
    end else if (busy_q) begin
      if (dev_ready) busy_q <= 1'b0;
    end else if (wr_stb) begin
      busy_q   <= 1'b1;
      dev_data <= wr_data;
    end
  end
endmodule

// File: rtl/chario_regfile.sv
module chario_regfile
  import chario_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_REGS-1:0] rd_stb,
  output logic [NUM_REGS-1:0] wr_stb,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_rdy,
  input  logic              rx_ovr,
  input  logic              tx_rdy,
  output logic              kie_q
);
  logic [NUM_REGS-1:0] hit;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rx_stat;
  logic [DATA_W-1:0]   tx_stat;
  logic [DATA_W-1:0]   ctrl_val;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hit[g]    = bus_sel && (bus_addr == ADDR_W'(g));
    assign rd_stb[g] = hit[g] & ~bus_wr;
    assign wr_stb[g] = hit[g] & bus_wr;
  end

  always_comb begin
    rx_stat           = '0;
    rx_stat[RDY_BIT]  = rx_rdy;
    rx_stat[OVR_BIT]  = rx_ovr;
    tx_stat           = '0;
    tx_stat[RDY_BIT]  = tx_rdy;
    ctrl_val          = '0;
    ctrl_val[KIE_BIT] = kie_q;
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      rd_stb[OFS_RXDATA]: rd_mux = rx_data;
      rd_stb[OFS_RXSTAT]: rd_mux = rx_stat;
      rd_stb[OFS_TXSTAT]: rd_mux = tx_stat;
      rd_stb[OFS_CTRL]:   rd_mux = ctrl_val;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      kie_q     <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      if (wr_stb[OFS_CTRL]) kie_q <= bus_wdata[KIE_BIT];
    end
  end
endmodule

// File: rtl/chario_mmio.sv
module chario_mmio
  import chario_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  output logic              kbd_ready,
  input  logic [DATA_W-1:0] kbd_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [DATA_W-1:0] disp_data,
  output logic              irq
);
  logic [NUM_REGS-1:0] rd_stb;
  logic [NUM_REGS-1:0] wr_stb;
  logic [DATA_W-1:0]   rx_data;
  logic                rx_rdy;
  logic                rx_ovr;
  logic                tx_rdy;
  logic                kbd_ie;

  chario_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr),
    .tx_rdy(tx_rdy), .kie_q(kbd_ie)
  );

  chario_rx_chan #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .dev_valid(kbd_valid), .dev_data(kbd_data), .dev_ready(kbd_ready),
    .data_rd(rd_stb[OFS_RXDATA]), .stat_rd(rd_stb[OFS_RXSTAT]),
    .data_q(rx_data), .rdy_q(rx_rdy), .ovr_q(rx_ovr)
  );

  chario_tx_chan #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb[OFS_TXDATA]), .wr_data(bus_wdata),
    .dev_valid(disp_valid), .dev_ready(disp_ready), .dev_data(disp_data),
    .rdy(tx_rdy)
  );

  assign irq = rx_rdy & kbd_ie;
endmodule

// File: rtl/chario_mmio_chk.sv
module chario_mmio_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kbd_valid,
  input logic              kbd_ready,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [DATA_W-1:0] disp_data,
  input logic              irq,
  input logic              kbd_ie
);
  // R5
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_data));

  // R7
  disp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !disp_valid);

  // R6
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && bus_sel && bus_wr && bus_addr == ADDR_W'(2) |=> $stable(disp_data));

  // R3
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == '0 && !kbd_valid |=> !irq);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && kbd_ready && kbd_ie && !(bus_sel && bus_wr && bus_addr == ADDR_W'(4)) |=> irq);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr > ADDR_W'(4) |=> bus_rdata == '0);
endmodule

bind chario_mmio chario_mmio_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .kbd_valid(kbd_valid),
  .kbd_ready(kbd_ready), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_data(disp_data), .irq(irq), .kbd_ie(kbd_ie)
);

// File: tb/chario_mmio_tb.sv
module chario_mmio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       kbd_valid = 1'b0;
  logic       kbd_ready;
  logic [7:0] kbd_data = '0;
  logic       disp_valid;
  logic       disp_ready = 1'b0;
  logic [7:0] disp_data;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  chario_mmio u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_ready(kbd_ready), .kbd_data(kbd_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_data(disp_data),
    .irq(irq)
  );

  // op: 0 write, 1 read and compare, 2 push keyboard character
  // fields: op[21:20] addr[19:17] data[16:9] expected rdata[8:1] expected irq[0]
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 3'd4, 8'h04, 8'h00, 1'b0},  // R8 enable keyboard interrupt
    {2'd1, 3'd4, 8'h00, 8'h04, 1'b0},  // R8 read back
    {2'd2, 3'd0, 8'h41, 8'h00, 1'b1},  // R2 R9 arrival raises irq
    {2'd1, 3'd1, 8'h00, 8'h08, 1'b1},  // R2 receive flag
    {2'd1, 3'd0, 8'h00, 8'h41, 1'b0},  // R3 R9 data read drops irq
    {2'd1, 3'd1, 8'h00, 8'h00, 1'b0},  // R3 flag cleared
    {2'd2, 3'd0, 8'h42, 8'h00, 1'b1},
    {2'd2, 3'd0, 8'h43, 8'h00, 1'b1},  // R4 overrun
    {2'd1, 3'd1, 8'h00, 8'h18, 1'b1},  // R4 overrun visible
    {2'd1, 3'd1, 8'h00, 8'h08, 1'b1},  // R4 cleared by status read
    {2'd1, 3'd0, 8'h00, 8'h43, 1'b0},  // R4 newest char kept
    {2'd1, 3'd5, 8'h00, 8'h00, 1'b0},  // R10 unmapped
    {2'd1, 3'd7, 8'h00, 8'h00, 1'b0},  // R10 unmapped
    {2'd0, 3'd4, 8'hFB, 8'h00, 1'b0},  // R8 other bits, enable off
    {2'd1, 3'd4, 8'h00, 8'h00, 1'b0},  // R8 only bit 2 kept
    {2'd2, 3'd0, 8'h44, 8'h00, 1'b0}   // R9 irq masked
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_data = d;
    @(posedge clk); #2;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #2;
    v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] d0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 disp_valid", disp_valid, 0);
    check("R1 kbd_ready", kbd_ready, 1);
    rd(3'd1, v); check("R1 rx status", v, 8'h00);
    rd(3'd3, v); check("R1 tx status", v, 8'h08);
    rd(3'd4, v); check("R1 control", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][21:20])
        2'd0: bus_op(1'b1, VEC[i][19:17], VEC[i][16:9]);
        2'd1: begin
          rd(VEC[i][19:17], v);
          check("R2/R3/R4/R8/R10 table rdata", v, VEC[i][8:1]);
        end
        default: push(VEC[i][16:9]);
      endcase
      check("R9 table irq", irq, VEC[i][0]);
    end
    rd(3'd0, v); check("R2 masked char", v, 8'h44);

    // R3 arrival in the same cycle as the data read
    push(8'h50);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0;
    kbd_valid = 1'b1; kbd_data = 8'h51;
    @(posedge clk); #2;
    d0 = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; kbd_valid = 1'b0;
    check("R3 same-cycle old data", d0, 8'h50);
    rd(3'd1, v); check("R3 same-cycle flag kept, no overrun", v, 8'h08);
    rd(3'd0, v); check("R3 new char", v, 8'h51);

    // R5 R6 R7 output path
    disp_ready = 1'b0;
    bus_op(1'b1, 3'd2, 8'h55);
    check("R5 disp_valid", disp_valid, 1);
    check("R5 disp_data", disp_data, 8'h55);
    rd(3'd3, v); check("R5 tx flag cleared", v, 8'h00);
    bus_op(1'b1, 3'd2, 8'h66);
    check("R6 busy write ignored", disp_data, 8'h55);
    check("R5 valid held", disp_valid, 1);
    @(negedge clk); disp_ready = 1'b1;
    @(posedge clk); #2;
    check("R7 valid dropped", disp_valid, 0);
    @(negedge clk); disp_ready = 1'b0;
    rd(3'd3, v); check("R7 tx flag set", v, 8'h08);
    check("R6 dropped byte not sent", disp_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule